// File: doc/BRIEF.md
# SPI Register-Access Transaction Engine

This block is the byte-level protocol layer of an SPI slave. It sits behind a shift register that delivers one strobe per received byte. It turns a short byte stream into accesses on a register-file port. The first byte carries the operation, the data length and the top four address bits. The second byte carries the low eight address bits. Between one and eight data bytes follow, least-significant byte first. For every byte slot the engine presents the byte the shifter must send back. That byte is a fixed sync code during the header, an ACK during write data, the register contents during read data, and a busy/done answer during the closing poll.

An optional CRC-8 byte closes each transaction when the `crc_en` input is high. Polynomial x^8+x^5+x^4+1 (0x31) is used, with the register cleared at each command byte and bits taken MSB first. The master supplies the CRC on writes, and the engine supplies it on reads. A watchdog counts clock cycles from the command byte to the final byte of the transaction. If the count goes past `tmo_limit`, the partial transaction is dropped and framing restarts. The integrator sets `tmo_limit` to the cycle count that gives 360 ms at the system clock.

The controller has five states. `ST_CMD` waits for a command byte and goes to `ST_ADDR` when one arrives. `ST_ADDR` takes the address byte and goes to `ST_DATA`; on reads it also raises the register request. `ST_DATA` moves the data bytes. After the last one it goes to `ST_CRC` when CRC mode is on, and to `ST_POLL` when it is off. `ST_CRC` takes the CRC byte and goes to `ST_POLL`. `ST_POLL` answers dummy bytes and goes back to `ST_CMD` after a byte that was answered ACK. From `ST_ADDR`, `ST_DATA` or `ST_CRC`, a watchdog expiry takes the engine back to `ST_CMD`.

Top module: `spi_regx_engine`

## Requirements
- R1: Command byte bits 7:6 select the operation: 00 is read, 10 is write, 01 and 11 are reserved. Bits 5:4 select the length: 00 gives 1 byte, 01 gives 2, 10 gives 4 and 11 gives 8. Bits 3:0 give address bits 11:8, and the second byte gives address bits 7:0. `reg_addr` and `reg_len` carry these values to the register port.
- R2: The transmit byte is 0xC1 for the command-byte slot and 0xC2 for the address-byte slot.
- R3: On a write, the transmit byte is ACK 0x41 for every data slot and for the CRC slot. The first data byte lands in `reg_wdata[7:0]`, and each later byte goes into the next higher lane.
- R4: On a read, the register request is raised in the cycle after the address byte. The read data bytes are returned in the following data slots, lowest lane first.
- R5: In the poll phase the transmit byte is NACK 0x4E while a register request is outstanding, and ACK 0x41 once it is done. A byte answered NACK is ignored. The byte after a byte answered ACK is taken as a new command (slot answer 0xC1).
- R6: With `crc_en` high, a read ends with one extra slot that carries CRC-8 (poly 0x31, initial 0x00, MSB first). The CRC covers the command byte, the address byte and the data bytes.
- R7: A write whose received CRC byte differs from the computed one makes no register request, and its poll answers ACK.
- R8: With `crc_en` low there is no CRC slot, and the poll follows the last data byte directly.
- R9: The watchdog counts from the command byte to the final byte of the transaction. If the transaction is still open more than `tmo_limit` cycles after the command byte, it is dropped with no register access. The next byte is then taken as a command.
- R10: A reserved operation takes its full length of bytes, answered ACK, and makes no register request. Its poll answers ACK.
- R11: While `reg_busy` is high, a raised `reg_req` stays high, and its address, direction and write data do not change.
- R12: After reset the transmit byte is 0xC1 and `reg_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a byte has been received |
| rx_byte | input | 8 | Received byte, valid with rx_valid |
| tx_byte | output | 8 | Byte to shift out in the next byte slot |
| crc_en | input | 1 | Enables the CRC byte on every transaction |
| tmo_limit | input | TMO_W | Transaction time limit in clock cycles |
| reg_req | output | 1 | Register access request, held until accepted |
| reg_we | output | 1 | 1 for write, 0 for read |
| reg_addr | output | 12 | Register address |
| reg_len | output | 2 | Length code of the access |
| reg_wdata | output | DATA_W | Write data, byte lanes in arrival order |
| reg_rdata | input | DATA_W | Read data, sampled when the request is accepted |
| reg_busy | input | 1 | Register file cannot accept; a request is accepted in a cycle where it is low |

## Verification
Each byte strobe changes the transmit byte one clock later. The bench checks the answer for a slot at the falling edge inside that slot's strobe cycle, so every check sees the state left by all earlier bytes. A register request appears one cycle after the byte that triggers it and is accepted at the next edge where `reg_busy` is low. The monitor compares write contents at the falling edge before that accepting edge. After a read request, the bench leaves at least three idle cycles before the first data slot, so the captured read data is settled when the engine presents it. The timeout case waits well past `tmo_limit` and normal traffic stays well under it, so neither depends on the exact expiry cycle.

// File: rtl/spi_regx_pkg.sv
package spi_regx_pkg;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_ADDR,
        ST_DATA,
        ST_CRC,
        ST_POLL
    } xfer_state_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_RSV_A = 2'b01,
        OP_WRITE = 2'b10,
        OP_RSV_B = 2'b11
    } xfer_op_e;

    localparam logic [7:0] SYNC_CMD  = 8'hC1;
    localparam logic [7:0] SYNC_ADDR = 8'hC2;
    localparam logic [7:0] RESP_ACK  = 8'h41;
    localparam logic [7:0] RESP_NACK = 8'h4E;
    localparam logic [7:0] CRC_POLY  = 8'h31;

    // One byte through the CRC-8 register, MSB first.
    function automatic logic [7:0] crc8_step(input logic [7:0] crc_in, input logic [7:0] din);
        logic [7:0] acc;
        acc = crc_in ^ din;
        for (int b = 0; b < 8; b++) begin
            acc = acc[7] ? ((acc << 1) ^ CRC_POLY) : (acc << 1);
        end
        return acc;
    endfunction

endpackage

// File: rtl/spi_regx_crc8.sv
module spi_regx_crc8
    import spi_regx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       step,
    input  logic [7:0] din,
    output logic [7:0] crc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= 8'h00;
        end else if (start) begin
            crc <= crc8_step(8'h00, din);
        end else if (step) begin
            crc <= crc8_step(crc, din);
        end
    end

endmodule

// File: rtl/spi_regx_watchdog.sv
module spi_regx_watchdog #(
    parameter int TMO_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);

    localparam int CNT_W = TMO_W + 1;

    logic [CNT_W-1:0] cnt;

    assign expired = cnt > {1'b0, limit};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (run && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/spi_regx_databuf.sv
module spi_regx_databuf #(
    parameter int NBYTES = 8,
    localparam int IDX_W = $clog2(NBYTES),
    localparam int DW    = NBYTES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DW-1:0]    load_data,
    input  logic             put,
    input  logic [IDX_W-1:0] put_idx,
    input  logic [7:0]       put_byte,
    input  logic [IDX_W-1:0] sel_idx,
    output logic [DW-1:0]    data,
    output logic [7:0]       sel_byte
);

    logic [7:0] lanes [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lanes[g] <= 8'h00;
            end else if (load) begin
                lanes[g] <= load_data[g*8 +: 8];
            end else if (put && (put_idx == IDX_W'(g))) begin
                lanes[g] <= put_byte;
            end
        end
        assign data[g*8 +: 8] = lanes[g];
    end

    assign sel_byte = lanes[sel_idx];

endmodule

// File: rtl/spi_regx_engine.sv
module spi_regx_engine
    import spi_regx_pkg::*;
#(
    parameter int TMO_W     = 24,
    parameter int MAX_BYTES = 8,
    localparam int DATA_W   = MAX_BYTES * 8,
    localparam int IDX_W    = $clog2(MAX_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic [7:0]        tx_byte,
    input  logic              crc_en,
    input  logic [TMO_W-1:0]  tmo_limit,
    output logic              reg_req,
    output logic              reg_we,
    output logic [11:0]       reg_addr,
    output logic [1:0]        reg_len,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic              reg_busy
);

    xfer_state_e      state, state_d;
    logic [1:0]       op;
    logic [1:0]       len_code;
    logic [11:0]      addr;
    logic [IDX_W-1:0] idx;
    logic             pend;

    logic             active, expired, abort, accept;
    logic             is_rd, is_wr;
    logic [IDX_W-1:0] last_idx;
    logic             crc_start, crc_step;
    logic [7:0]       crc_din, crc_val;
    logic             buf_put, buf_load;
    logic [7:0]       buf_sel;
    logic             issue_rd, issue_wr;

    assign is_rd    = (op == OP_READ);
    assign is_wr    = (op == OP_WRITE);
    assign last_idx = IDX_W'((1 << len_code) - 1);
    assign active   = (state == ST_ADDR) || (state == ST_DATA) || (state == ST_CRC);
    assign abort    = active && expired;
    assign accept   = pend && !reg_busy;
    assign buf_load = accept && !reg_we;

    spi_regx_crc8 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .start (crc_start),
        .step  (crc_step),
        .din   (crc_din),
        .crc   (crc_val)
    );

    spi_regx_watchdog #(.TMO_W(TMO_W)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state == ST_CMD),
        .run     (active),
        .limit   (tmo_limit),
        .expired (expired)
    );

    spi_regx_databuf #(.NBYTES(MAX_BYTES)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (buf_load),
        .load_data (reg_rdata),
        .put       (buf_put),
        .put_idx   (idx),
        .put_byte  (rx_byte),
        .sel_idx   (idx),
        .data      (reg_wdata),
        .sel_byte  (buf_sel)
    );

    // Next-state and per-byte strobes.
    always_comb begin
        state_d   = state;
        crc_start = 1'b0;
        crc_step  = 1'b0;
        crc_din   = rx_byte;
        buf_put   = 1'b0;
        issue_rd  = 1'b0;
        issue_wr  = 1'b0;
        if (abort) begin
            state_d = ST_CMD;
        end else if (rx_valid) begin
            unique case (state)
                ST_CMD: begin
                    crc_start = 1'b1;
                    state_d   = ST_ADDR;
                end
                ST_ADDR: begin
                    crc_step = 1'b1;
                    issue_rd = is_rd;
                    state_d  = ST_DATA;
                end
                ST_DATA: begin
                    crc_step = 1'b1;
                    crc_din  = is_rd ? buf_sel : rx_byte;
                    buf_put  = is_wr;
                    if (idx == last_idx) begin
                        state_d  = crc_en ? ST_CRC : ST_POLL;
                        issue_wr = is_wr && !crc_en;
                    end
                end
                ST_CRC: begin
                    issue_wr = is_wr && (rx_byte == crc_val);
                    state_d  = ST_POLL;
                end
                ST_POLL: begin
                    if (!pend) state_d = ST_CMD;
                end
                default: state_d = ST_CMD;
            endcase
        end
    end

    // State register and transaction context.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_CMD;
            op       <= OP_READ;
            len_code <= 2'b00;
            addr     <= 12'h000;
            idx      <= '0;
            pend     <= 1'b0;
        end else begin
            state <= state_d;
            if (!abort && rx_valid) begin
                if (state == ST_CMD) begin
                    op         <= rx_byte[7:6];
                    len_code   <= rx_byte[5:4];
                    addr[11:8] <= rx_byte[3:0];
                end
                if (state == ST_ADDR) begin
                    addr[7:0] <= rx_byte;
                    idx       <= '0;
                end
                if (state == ST_DATA) begin
                    idx <= idx + 1'b1;
                end
            end
            if (abort) begin
                pend <= 1'b0;
            end else if (issue_rd || issue_wr) begin
                pend <= 1'b1;
            end else if (accept) begin
                pend <= 1'b0;
            end
        end
    end

    // Outputs.
    always_comb begin
        unique case (state)
            ST_CMD:  tx_byte = SYNC_CMD;
            ST_ADDR: tx_byte = SYNC_ADDR;
            ST_DATA: tx_byte = is_rd ? buf_sel : RESP_ACK;
            ST_CRC:  tx_byte = is_rd ? crc_val : RESP_ACK;
            ST_POLL: tx_byte = pend ? RESP_NACK : RESP_ACK;
            default: tx_byte = SYNC_CMD;
        endcase
    end

    assign reg_req  = pend;
    assign reg_we   = is_wr;
    assign reg_addr = addr;
    assign reg_len  = len_code;

endmodule

// File: rtl/spi_regx_sva.sv
module spi_regx_sva #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic [7:0]        tx_byte,
    input logic              reg_req,
    input logic              reg_we,
    input logic              reg_busy,
    input logic [11:0]       reg_addr,
    input logic [DATA_W-1:0] reg_wdata
);

    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_busy) |=> (reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata)));

    a_r11_single_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_busy) |=> !reg_req);

    a_r5_nack_while_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we) |-> (tx_byte == 8'h4E));

    a_r4_req_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_req) |-> $past(rx_valid));

endmodule

bind spi_regx_engine spi_regx_sva #(.DATA_W(DATA_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .tx_byte   (tx_byte),
    .reg_req   (reg_req),
    .reg_we    (reg_we),
    .reg_busy  (reg_busy),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata)
);

// File: tb/spi_regx_engine_tb.sv
module spi_regx_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 3;

    typedef struct packed {
        logic [11:0] a;
        logic [1:0]  l;
        logic [63:0] d;
    } wr_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic [7:0]  tx_byte;
    logic        crc_en = 1'b0;
    logic [23:0] tmo_limit = 24'd200;
    logic        reg_req, reg_we;
    logic [11:0] reg_addr;
    logic [1:0]  reg_len;
    logic [63:0] reg_wdata, reg_rdata;
    logic        reg_busy = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int n_acc    = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    wr_item_t   wr_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_regx_engine u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .tx_byte   (tx_byte),
        .crc_en    (crc_en),
        .tmo_limit (tmo_limit),
        .reg_req   (reg_req),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_len   (reg_len),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .reg_busy  (reg_busy)
    );

    function automatic logic [7:0] rd_pat(input logic [11:0] a, input int k);
        return (a[7:0] ^ 8'h5A) + 8'(k * 17);
    endfunction

    always_comb begin
        for (int k = 0; k < 8; k++) reg_rdata[k*8 +: 8] = rd_pat(reg_addr, k);
    end

    // Bit-serial CRC-8, poly 0x31, MSB first.
    function automatic logic [7:0] crc_b(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        logic fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[7] ^ d[i];
            r = {r[6:0], 1'b0};
            if (fb) r = r ^ 8'h31;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: slot answers and register accesses.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected byte slot", {56'h0, tx_byte}, 64'h0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(tx_byte == e, t, {56'h0, tx_byte}, {56'h0, e});
                end
            end
            if (reg_req && !reg_busy) begin
                n_acc++;
                if (reg_we) begin
                    if (wr_q.size() == 0) begin
                        check(1'b0, "R7 R10 unexpected write", {52'h0, reg_addr}, 64'h0);
                    end else begin
                        wr_item_t w;
                        logic [63:0] m;
                        w = wr_q.pop_front();
                        m = (w.l == 2'b11) ? '1 : ((64'd1 << (8 * (1 << w.l))) - 1);
                        check(reg_addr == w.a, "R1 write address", {52'h0, reg_addr}, {52'h0, w.a});
                        check(reg_len == w.l, "R1 write length", {62'h0, reg_len}, {62'h0, w.l});
                        check((reg_wdata & m) == w.d, "R3 write data lanes", reg_wdata & m, w.d);
                    end
                end
            end
        end
    end

    task automatic xfer(input logic [7:0] b, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk); #2;
        rx_valid = 1'b1;
        rx_byte  = b;
        @(posedge clk); #2;
        rx_valid = 1'b0;
        repeat (GAP) @(posedge clk);
    endtask

    task automatic run_write(input logic [1:0] lc, input logic [11:0] a, input logic [63:0] d,
                             input bit corrupt, input string tag);
        logic [7:0] cmd, c;
        int n;
        cmd = {2'b10, lc, a[11:8]};
        n = 1 << lc;
        if (!(crc_en && corrupt)) begin
            wr_q.push_back('{a: a, l: lc,
                d: d & ((lc == 2'b11) ? '1 : ((64'd1 << (8 * n)) - 1))});
        end
        c = crc_b(8'h00, cmd);
        xfer(cmd, 8'hC1, {"R2 command slot ", tag});
        c = crc_b(c, a[7:0]);
        xfer(a[7:0], 8'hC2, {"R2 address slot ", tag});
        for (int i = 0; i < n; i++) begin
            c = crc_b(c, d[i*8 +: 8]);
            xfer(d[i*8 +: 8], 8'h41, {"R3 write data ack ", tag});
        end
        if (crc_en) xfer(corrupt ? (c ^ 8'h01) : c, 8'h41, {"R3 crc slot ack ", tag});
    endtask

    task automatic run_read(input logic [1:0] lc, input logic [11:0] a, input string tag);
        logic [7:0] cmd, c, b;
        cmd = {2'b00, lc, a[11:8]};
        c = crc_b(8'h00, cmd);
        xfer(cmd, 8'hC1, {"R2 command slot ", tag});
        c = crc_b(c, a[7:0]);
        xfer(a[7:0], 8'hC2, {"R2 address slot ", tag});
        for (int i = 0; i < (1 << lc); i++) begin
            b = rd_pat(a, i);
            c = crc_b(c, b);
            xfer(8'h00, b, {"R4 read data ", tag});
        end
        if (crc_en) xfer(8'h00, c, {"R6 read crc ", tag});
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int acc0;
        repeat (3) @(posedge clk);
        #2;
        check(tx_byte == 8'hC1, "R12 reset tx", {56'h0, tx_byte}, 64'hC1);
        check(reg_req == 1'b0, "R12 reset req", {63'h0, reg_req}, 64'h0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R8 write, 2 bytes, no CRC slot; then surplus byte starts a read
        run_write(2'b01, 12'h34C, 64'h2211, 1'b0, "R8");
        xfer(8'hFF, 8'h41, "R5 poll ack after write");
        run_read(2'b00, 12'h000, "R5 surplus byte is command");
        xfer(8'hFF, 8'h41, "R5 poll ack after read");

        // R5 busy register file
        @(posedge clk); #2;
        reg_busy = 1'b1;
        run_write(2'b00, 12'h510, 64'hAB, 1'b0, "R5");
        xfer(8'hFF, 8'h4E, "R5 poll nack while busy");
        xfer(8'h80, 8'h4E, "R5 ignored byte while busy");
        check(reg_req == 1'b1 && reg_addr == 12'h510, "R11 request held", {51'h0, reg_req, reg_addr}, 64'h1510);
        @(posedge clk); #2;
        reg_busy = 1'b0;
        repeat (3) @(posedge clk);
        xfer(8'hFF, 8'h41, "R5 poll ack after busy");

        // R4 read 4 bytes, no CRC
        run_read(2'b10, 12'hA77, "R4");
        xfer(8'hFF, 8'h41, "R5 poll ack read");

        // R6 CRC mode
        crc_en = 1'b1;
        run_write(2'b11, 12'hB02, 64'h8877665544332211, 1'b0, "R6 crc write");
        xfer(8'hFF, 8'h41, "R6 poll ack crc write");
        acc0 = n_acc;
        run_write(2'b00, 12'h005, 64'h3C, 1'b1, "R7 bad crc");
        xfer(8'hFF, 8'h41, "R7 poll ack bad crc");
        check(n_acc == acc0, "R7 no access on bad crc", 64'(n_acc), 64'(acc0));
        run_read(2'b01, 12'hFE0, "R6");
        xfer(8'hFF, 8'h41, "R6 poll ack crc read");
        crc_en = 1'b0;

        // R10 reserved op
        acc0 = n_acc;
        xfer(8'h50, 8'hC1, "R10 reserved command slot");
        xfer(8'h00, 8'hC2, "R10 reserved address slot");
        xfer(8'h12, 8'h41, "R10 reserved data ack");
        xfer(8'h34, 8'h41, "R10 reserved data ack");
        xfer(8'hFF, 8'h41, "R10 reserved poll ack");
        check(n_acc == acc0, "R10 reserved no access", 64'(n_acc), 64'(acc0));

        // R9 timeout
        tmo_limit = 24'd40;
        acc0 = n_acc;
        xfer(8'h81, 8'hC1, "R9 abandoned command slot");
        xfer(8'h01, 8'hC2, "R9 abandoned address slot");
        repeat (60) @(posedge clk);
        run_write(2'b01, 12'h020, 64'hBEEF, 1'b0, "R9 after timeout");
        xfer(8'hFF, 8'h41, "R9 poll ack");
        check(n_acc == acc0 + 1, "R9 only restarted write accessed", 64'(n_acc), 64'(acc0 + 1));

        repeat (5) @(posedge clk);
        check(exp_q.size() == 0, "R2 all slots seen", 64'(exp_q.size()), 64'h0);
        check(wr_q.size() == 0, "R3 all writes seen", 64'(wr_q.size()), 64'h0);
        finish_run();
    end

endmodule